// File: doc/BRIEF.md
# Segment Line Latch and Drive Level Selector

This block holds one display line for a column of LCD segment outputs and turns every held pixel bit into a 2-bit code. The code picks which of four bias rails the analog switch for that output connects to the panel. Upstream logic assembles the next line into a wide staging register. A strobe then moves that line into this block's holding register, and the new codes apply from the clock edge that sees the strobe fall. The analog switches and the bias rails are outside this block and appear here only as the codes.

The frame alternation input swaps the pair of rails in use, so that the panel sees no net DC across a frame pair. It acts on the codes directly and needs no new strobe. A blanking input, active low, forces every output onto the selected-high rail, whatever the line data and the alternation phase are. The number of outputs is a parameter, 80 by default.

Top module: `drv_line_stage`

## Requirements
- R1: The block has NSEG outputs (default 80), each a 2-bit code in `lvl_code[2*i+1:2*i]` for segment i. The codes are 00 = selected-high rail, 01 = unselected-high rail, 10 = unselected-low rail, 11 = selected-low rail.
- R2: At the first rising clock edge where `load` is sampled low after being sampled high on the edge before, the holding register takes `line_in`. The codes reflect the new line from that edge on.
- R3: At every other clock edge the holding register keeps its value. This covers `load` held high, `load` held low and a rising `load`. Changes on `line_in` then have no effect on `lvl_code`.
- R4: With `disp_on` high and `alt_m` low, a held bit of 0 gives code 01 and a held bit of 1 gives code 00.
- R5: With `disp_on` high and `alt_m` high, a held bit of 0 gives code 10 and a held bit of 1 gives code 11.
- R6: With `disp_on` low, every output gives code 00, whatever the held data and `alt_m` are.
- R7: `alt_m` and `disp_on` act on `lvl_code` combinationally. Toggling `alt_m` with `disp_on` high changes every code without a new load.
- R8: While `rst_n` is low the holding register is cleared to all zeros. Directly after reset, with `disp_on` high and `alt_m` low, every code is 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; `load` is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Line transfer strobe; a falling transition triggers the capture |
| line_in | input | NSEG | Staged line from the first latch |
| alt_m | input | 1 | Frame alternation phase |
| disp_on | input | 1 | Display enable; low forces all outputs to code 00 |
| lvl_code | output | 2*NSEG | Per-segment drive level code |

## Verification
Random lines are loaded and then viewed under all four combinations of `alt_m` and `disp_on`. This separates the pixel-bit mapping of each phase from the blanking override, and shows that the phase swaps without a new strobe. Directed lines of all ones, all zeros and alternating bits expose swapped or stuck segment fields. Strobes held high, held low or only rising, each with `line_in` changing, show that only a falling transition captures data. The reset check covers the cleared state.

// File: rtl/drv_line_pkg.sv
package drv_line_pkg;

   typedef enum logic [1:0] {
      LVL_SEL_HI   = 2'b00,
      LVL_UNSEL_HI = 2'b01,
      LVL_UNSEL_LO = 2'b10,
      LVL_SEL_LO   = 2'b11
   } drv_lvl_e;

   // Rail choice for one segment: phase picks the rail pair, pixel picks within it.
   function automatic drv_lvl_e pick_level(input logic px, input logic phase, input logic on);
      drv_lvl_e r;
      if (!on)
         r = LVL_SEL_HI;
      else if (!phase)
         r = px ? LVL_SEL_HI : LVL_UNSEL_HI;
      else
         r = px ? LVL_SEL_LO : LVL_UNSEL_LO;
      return r;
   endfunction

endpackage

// File: rtl/drv_fall_det.sv
module drv_fall_det (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic fall
);
   logic strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= strobe;
   end

   assign fall = strobe_q & ~strobe;
endmodule

// File: rtl/drv_line_reg.sv
module drv_line_reg #(
   parameter int unsigned WIDTH = 80
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (take) q <= d;
   end
endmodule

// File: rtl/drv_level_cell.sv
module drv_level_cell
   import drv_line_pkg::*;
(
   input  logic       px,
   input  logic       phase,
   input  logic       on,
   output logic [1:0] code
);
   drv_lvl_e lvl;
   always_comb lvl = pick_level(px, phase, on);
   assign code = lvl;
endmodule

// File: rtl/drv_line_stage.sv
module drv_line_stage #(
   parameter int unsigned NSEG = 80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [NSEG-1:0]   line_in,
   input  logic              alt_m,
   input  logic              disp_on,
   output logic [2*NSEG-1:0] lvl_code
);
   localparam int unsigned CODE_W = 2*NSEG;

   if (NSEG < 1) begin : g_bad_nseg
      $error("drv_line_stage: NSEG must be at least 1");
   end

   logic            cap_fall;
   logic [NSEG-1:0] line_q;

   drv_fall_det u_fall (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (load),
      .fall   (cap_fall)
   );

   drv_line_reg #(.WIDTH(NSEG)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (cap_fall),
      .d     (line_in),
      .q     (line_q)
   );

   for (genvar i = 0; i < NSEG; i++) begin : g_seg
      drv_level_cell u_cell (
         .px    (line_q[i]),
         .phase (alt_m),
         .on    (disp_on),
         .code  (lvl_code[2*i +: 2])
      );
   end

   if (CODE_W != $bits(lvl_code)) begin : g_bad_width
      $error("drv_line_stage: code bus width mismatch");
   end
endmodule

// File: rtl/drv_line_chk.sv
module drv_line_chk #(
   parameter int unsigned NSEG = 80
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load,
   input logic [NSEG-1:0]   line_in,
   input logic              alt_m,
   input logic              disp_on,
   input logic [2*NSEG-1:0] lvl_code,
   input logic [NSEG-1:0]   line_q
);
   logic            ck_load_q;
   logic [NSEG-1:0] hi_bits;
   logic [NSEG-1:0] lo_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ck_load_q <= 1'b0;
      else        ck_load_q <= load;
   end

   for (genvar i = 0; i < NSEG; i++) begin : g_split
      assign hi_bits[i] = lvl_code[2*i+1];
      assign lo_bits[i] = lvl_code[2*i];
   end

   // R2
   assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_load_q && !load) |=> (line_q == $past(line_in)));
   // R3
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ck_load_q && !load) |=> $stable(line_q));
   // R4
   assert_phase0_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_on && !alt_m) |-> (hi_bits == '0 && lo_bits == ~line_q));
   // R5
   assert_phase1_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_on && alt_m) |-> (hi_bits == '1 && lo_bits == line_q));
   // R6
   assert_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_on |-> (lvl_code == '0));
   // R7
   assert_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_on && $past(disp_on) && $stable(line_q) && alt_m != $past(alt_m))
      |-> ((hi_bits ^ $past(hi_bits)) == '1));
   // R8
   assert_reset_R8: assert property (@(posedge clk)
      !rst_n |=> (line_q == '0));
endmodule

bind drv_line_stage drv_line_chk #(.NSEG(NSEG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .load     (load),
   .line_in  (line_in),
   .alt_m    (alt_m),
   .disp_on  (disp_on),
   .lvl_code (lvl_code),
   .line_q   (line_q)
);

// File: tb/sim_drv_line_stage.sv
`timescale 1ns/1ps
module sim_drv_line_stage;
   localparam int N = 80;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           load = 1'b0;
   logic [N-1:0]   line_in = '0;
   logic           alt_m = 1'b0;
   logic           disp_on = 1'b1;
   logic [2*N-1:0] lvl_code;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [N-1:0] model = '0;

   always #4 clk = ~clk;

   drv_line_stage #(.NSEG(N)) u0 (
      .clk(clk), .rst_n(rst_n), .load(load), .line_in(line_in),
      .alt_m(alt_m), .disp_on(disp_on), .lvl_code(lvl_code)
   );

   // Expected codes straight from the rail table in the requirements.
   function automatic logic [2*N-1:0] expect_codes(input logic [N-1:0] d, input logic m, input logic on);
      logic [2*N-1:0] r;
      for (int i = 0; i < N; i++) begin
         if (!on)                r[2*i +: 2] = 2'b00;
         else if (!m && !d[i])   r[2*i +: 2] = 2'b01;
         else if (!m &&  d[i])   r[2*i +: 2] = 2'b00;
         else if ( m && !d[i])   r[2*i +: 2] = 2'b10;
         else                    r[2*i +: 2] = 2'b11;
      end
      return r;
   endfunction

   function automatic logic [N-1:0] rand_line();
      return {$urandom(), $urandom(), $urandom()};
   endfunction

   task automatic check(input string req, input logic m, input logic on);
      logic [2*N-1:0] e;
      alt_m = m; disp_on = on;
      #1;
      e = expect_codes(model, m, on);
      tests++;
      if (lvl_code !== e) begin
         fails++;
         $display("FAIL %s m=%0b on=%0b act=%h exp=%h", req, m, on, lvl_code, e);
      end
   endtask

   task automatic do_load(input logic [N-1:0] d);
      @(negedge clk); load = 1'b1; line_in = d;
      @(negedge clk); load = 1'b0;
      @(negedge clk); model = d; line_in = ~d;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8: cleared line, all unselected-high
      check("R8", 1'b0, 1'b1);

      // R1 directed patterns, phase 0
      do_load('1);           check("R1 ones R4", 1'b0, 1'b1);
      do_load('0);           check("R1 zeros R5", 1'b1, 1'b1);
      do_load({(N/2){2'b10}}); check("R1 alt R4", 1'b0, 1'b1);
                             check("R1 alt R5", 1'b1, 1'b1);

      // R2 random lines, all four control combos (R4 R5 R6 R7)
      for (int k = 0; k < 20; k++) begin
         do_load(rand_line());
         check("R2", 1'b0, 1'b1);
         check("R7 R5", 1'b1, 1'b1);
         check("R7 R4", 1'b0, 1'b1);
         check("R6", $urandom_range(0, 1), 1'b0);
         check("R6 m1", 1'b1, 1'b0);
      end

      // R3: load held low, line changes
      do_load(rand_line());
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); line_in = rand_line();
         @(negedge clk);
         check("R3 low", 1'b0, 1'b1);
      end
      // R3: load held high with line changes, then a rise only
      @(negedge clk); load = 1'b1; line_in = rand_line();
      @(negedge clk); line_in = rand_line();
      @(negedge clk);
      check("R3 high", 1'b1, 1'b1);
      @(negedge clk); load = 1'b0; line_in = model; // fall captures model again
      @(negedge clk); line_in = rand_line();
      check("R3 refill", 1'b0, 1'b1);
      @(negedge clk); load = 1'b1; line_in = rand_line(); // rise only
      @(negedge clk);
      check("R3 rise", 1'b1, 1'b1);
      // R2: falling edge now captures what is on line_in
      line_in = rand_line();
      @(negedge clk); load = 1'b0;
      @(negedge clk); model = line_in; line_in = rand_line();
      check("R2 fall", 1'b0, 1'b1);

      // R8 again: reset mid-run clears line
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1; model = '0;
      check("R8 rerun", 1'b0, 1'b1);

      finish_run();
   end
endmodule